// File: doc/BRIEF.md
# Gated Configuration Register Controller

This block holds a four-bit configuration word and a small set of protected registers. Three control bits decide whether software may write the protected targets. These targets are a two-bit PHY mode field, a bank of LED control registers, and a 16-byte address shadow store. A fourth bit selects how the interrupt pad signals a pending request. The non-volatile loader port writes any target at any time and is never gated. This lets a board image preset fields that software cannot change.

Software reads and writes through one word-addressed port. In the same cycle, the loader uses a separate address and data path. The interrupt pad is presented as a data-out and output-enable pair. The pad runs in one of two modes: open-drain active-low for a shared line, or push-pull active-high for a dedicated line. Only the asynchronous hard reset clears the control bits. A soft reset or a stop request leaves every stored value intact; while either is asserted, the pending interrupt is masked at the pad.

Top module: `cfg_gate_ctrl`

## Requirements
- R1: Hard reset (rst_ni low) clears the control bits and every protected target, so every address reads 0.
- R2: Address 0 holds the control word and is always software-writable. Bit 13 is PHY-mode write enable, bit 12 is LED write enable, bit 8 is shadow write enable, and bit 7 is interrupt mode (0 level, 1 edge). All other bits read 0.
- R3: A loader write to address 0 takes bits 15..0 of its data. When the loader and software write the same address in the same cycle, the loader value is stored.
- R4: The PHY mode field is bits 1..0 of address 1. Software writes to it take effect only while bit 13 of the control word is 1. Loader writes always take effect.
- R5: LED registers sit at addresses 2..6, 16 bits each, zero-extended on read. Software writes take effect only while bit 12 is 1. A blocked write leaves the stored value unchanged.
- R6: The 16-byte shadow store is four 32-bit words at addresses 8..11. Software writes take effect only while bit 8 is 1. Loader writes always take effect.
- R7: In level mode, a pending interrupt gives int_oe_o=1 and int_do_o=0. With no interrupt pending, int_oe_o=0 and int_do_o=0.
- R8: In edge mode, int_oe_o is 1 and int_do_o equals the pending request.
- R9: soft_rst_i and stop_i leave the control bits and targets unchanged. While either is high, the interrupt counts as not pending at the pad.
- R10: Addresses 7 and 12..31 read 0, and writes to them change no stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hard reset |
| soft_rst_i | input | 1 | Soft reset request |
| stop_i | input | 1 | Stop request |
| sw_we_i | input | 1 | Software write strobe |
| sw_addr_i | input | 5 | Software word address, read and write |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Read data for sw_addr_i, combinational |
| nv_we_i | input | 1 | Loader write strobe |
| nv_addr_i | input | 5 | Loader word address |
| nv_wdata_i | input | 32 | Loader write data |
| irq_i | input | 1 | Interrupt pending |
| int_do_o | output | 1 | Interrupt pad data out |
| int_oe_o | output | 1 | Interrupt pad output enable |

## Verification
The bench builds the block with its default parameters: a 5-bit address, five 16-bit LED registers, a 16-byte shadow store and a 2-bit PHY field. With these values the whole map, including both unmapped gaps, fits in a 0..31 address draw. Random traffic therefore mixes gated, ungated and unmapped writes, and toggles the enables between them. Directed cases cover blocked writes followed by read-back, same-cycle loader-over-software priority, and both pad modes with soft reset and stop asserted.

// File: rtl/cfg_gate_pkg.sv
package cfg_gate_pkg;
  localparam int DATA_W      = 32;
  localparam int BIT_PHY_EN  = 13;
  localparam int BIT_LED_EN  = 12;
  localparam int BIT_SH_EN   = 8;
  localparam int BIT_IRQ_EDG = 7;
  localparam logic [DATA_W-1:0] NV_MASK = 32'h0000_ffff;

  typedef struct packed {
    logic phy_en;
    logic led_en;
    logic sh_en;
    logic irq_edge;
  } ctrl_t;

  function automatic ctrl_t to_ctrl(logic [DATA_W-1:0] d);
    return '{phy_en: d[BIT_PHY_EN], led_en: d[BIT_LED_EN],
             sh_en: d[BIT_SH_EN], irq_edge: d[BIT_IRQ_EDG]};
  endfunction

  function automatic logic [DATA_W-1:0] from_ctrl(ctrl_t c);
    logic [DATA_W-1:0] d;
    d = '0;
    d[BIT_PHY_EN]  = c.phy_en;
    d[BIT_LED_EN]  = c.led_en;
    d[BIT_SH_EN]   = c.sh_en;
    d[BIT_IRQ_EDG] = c.irq_edge;
    return d;
  endfunction
endpackage

// File: rtl/cfg_gated_reg.sv
module cfg_gated_reg #(
  parameter int          W      = 8,
  parameter int          ADDR_W = 5,
  parameter int unsigned ADDR   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_i,
  input  logic              sw_we_i,
  input  logic [ADDR_W-1:0] sw_addr_i,
  input  logic [W-1:0]      sw_wdata_i,
  input  logic              nv_we_i,
  input  logic [ADDR_W-1:0] nv_addr_i,
  input  logic [W-1:0]      nv_wdata_i,
  output logic [W-1:0]      q_o
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ADDR);

  logic nv_hit, sw_hit;
  assign nv_hit = nv_we_i && (nv_addr_i == MY_ADDR);
  assign sw_hit = sw_we_i && (sw_addr_i == MY_ADDR) && gate_i;

  // loader path is never gated and wins a same-cycle collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (nv_hit) q_o <= nv_wdata_i;
    else if (sw_hit) q_o <= sw_wdata_i;
  end
endmodule

// File: rtl/cfg_irq_pad.sv
module cfg_irq_pad (
  input  logic irq_i,
  input  logic mask_i,
  input  logic edge_i,
  output logic do_o,
  output logic oe_o
);
  logic pend;
  assign pend = irq_i & ~mask_i;
  // level: open-drain low when pending; edge: push-pull high-true
  assign do_o = edge_i & pend;
  assign oe_o = edge_i | pend;
endmodule

// File: rtl/cfg_gate_ctrl.sv
module cfg_gate_ctrl
  import cfg_gate_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int PHY_W    = 2,
  parameter int LED_N    = 5,
  parameter int LED_W    = 16,
  parameter int SH_BYTES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              stop_i,
  input  logic              sw_we_i,
  input  logic [ADDR_W-1:0] sw_addr_i,
  input  logic [31:0]       sw_wdata_i,
  output logic [31:0]       sw_rdata_o,
  input  logic              nv_we_i,
  input  logic [ADDR_W-1:0] nv_addr_i,
  input  logic [31:0]       nv_wdata_i,
  input  logic              irq_i,
  output logic              int_do_o,
  output logic              int_oe_o
);
  localparam int SH_WORDS = SH_BYTES / 4;
  localparam int A_CTRL   = 0;
  localparam int A_PHY    = 1;
  localparam int A_LED    = 2;
  localparam int A_SH     = ((A_LED + LED_N + 3) / 4) * 4;

  ctrl_t            ctrl;
  logic [3:0]       ctrl_q;
  logic [PHY_W-1:0] phy_q;
  logic [LED_W-1:0] led_q [LED_N];
  logic [31:0]      sh_q  [SH_WORDS];

  assign ctrl = ctrl_t'(ctrl_q);

  // control word: always writable, loader limited to bits 15..0
  cfg_gated_reg #(.W(4), .ADDR_W(ADDR_W), .ADDR(A_CTRL)) u_ctrl (
    .clk_i, .rst_ni, .gate_i(1'b1),
    .sw_we_i, .sw_addr_i, .sw_wdata_i(from_ctrl_bits(sw_wdata_i)),
    .nv_we_i, .nv_addr_i, .nv_wdata_i(from_ctrl_bits(nv_wdata_i & NV_MASK)),
    .q_o(ctrl_q)
  );

  function automatic logic [3:0] from_ctrl_bits(logic [31:0] d);
    return 4'(to_ctrl(d));
  endfunction

  cfg_gated_reg #(.W(PHY_W), .ADDR_W(ADDR_W), .ADDR(A_PHY)) u_phy (
    .clk_i, .rst_ni, .gate_i(ctrl.phy_en),
    .sw_we_i, .sw_addr_i, .sw_wdata_i(sw_wdata_i[PHY_W-1:0]),
    .nv_we_i, .nv_addr_i, .nv_wdata_i(nv_wdata_i[PHY_W-1:0]),
    .q_o(phy_q)
  );

  for (genvar i = 0; i < LED_N; i++) begin : g_led
    cfg_gated_reg #(.W(LED_W), .ADDR_W(ADDR_W), .ADDR(A_LED + i)) u_led (
      .clk_i, .rst_ni, .gate_i(ctrl.led_en),
      .sw_we_i, .sw_addr_i, .sw_wdata_i(sw_wdata_i[LED_W-1:0]),
      .nv_we_i, .nv_addr_i, .nv_wdata_i(nv_wdata_i[LED_W-1:0]),
      .q_o(led_q[i])
    );
  end

  for (genvar i = 0; i < SH_WORDS; i++) begin : g_sh
    cfg_gated_reg #(.W(32), .ADDR_W(ADDR_W), .ADDR(A_SH + i)) u_sh (
      .clk_i, .rst_ni, .gate_i(ctrl.sh_en),
      .sw_we_i, .sw_addr_i, .sw_wdata_i,
      .nv_we_i, .nv_addr_i, .nv_wdata_i,
      .q_o(sh_q[i])
    );
  end

  always_comb begin
    sw_rdata_o = '0;
    if (sw_addr_i == ADDR_W'(A_CTRL)) sw_rdata_o = from_ctrl(ctrl);
    if (sw_addr_i == ADDR_W'(A_PHY))  sw_rdata_o = 32'(phy_q);
    for (int i = 0; i < LED_N; i++)
      if (sw_addr_i == ADDR_W'(A_LED + i)) sw_rdata_o = 32'(led_q[i]);
    for (int i = 0; i < SH_WORDS; i++)
      if (sw_addr_i == ADDR_W'(A_SH + i)) sw_rdata_o = sh_q[i];
  end

  cfg_irq_pad u_pad (
    .irq_i,
    .mask_i(soft_rst_i | stop_i),
    .edge_i(ctrl.irq_edge),
    .do_o(int_do_o),
    .oe_o(int_oe_o)
  );
endmodule

// File: rtl/cfg_gate_ctrl_chk.sv
module cfg_gate_ctrl_chk #(
  parameter int ADDR_W = 5,
  parameter int PHY_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              stop_i,
  input logic              sw_we_i,
  input logic [ADDR_W-1:0] sw_addr_i,
  input logic [31:0]       sw_wdata_i,
  input logic [31:0]       sw_rdata_o,
  input logic              nv_we_i,
  input logic [ADDR_W-1:0] nv_addr_i,
  input logic [31:0]       nv_wdata_i,
  input logic              irq_i,
  input logic              int_do_o,
  input logic              int_oe_o,
  input logic [3:0]        ctrl_q,
  input logic [PHY_W-1:0]  phy_q
);
  logic pend, edge_m;
  logic sw_ctrl, nv_ctrl, sw_phy, nv_phy;
  assign pend    = irq_i && !soft_rst_i && !stop_i;
  assign edge_m  = ctrl_q[0];
  assign sw_ctrl = sw_we_i && sw_addr_i == '0;
  assign nv_ctrl = nv_we_i && nv_addr_i == '0;
  assign sw_phy  = sw_we_i && sw_addr_i == ADDR_W'(1);
  assign nv_phy  = nv_we_i && nv_addr_i == ADDR_W'(1);

  always @(posedge clk_i)
    if (!rst_ni) assert_reset_clear_R1: assert (ctrl_q == 4'b0 && phy_q == '0);

  assert_ctrl_reserved_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_addr_i == '0 |-> (sw_rdata_o & ~32'h0000_3180) == 32'h0);

  assert_nv_priority_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_ctrl && nv_ctrl) |=> ctrl_q == {$past(nv_wdata_i[13]), $past(nv_wdata_i[12]),
                                         $past(nv_wdata_i[8]), $past(nv_wdata_i[7])});

  assert_phy_blocked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_phy && !ctrl_q[3] && !nv_phy) |=> $stable(phy_q));

  assert_level_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_m && !pend) |-> (!int_oe_o && !int_do_o));

  assert_level_active_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_m && pend) |-> (int_oe_o && !int_do_o));

  assert_edge_drive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_m |-> (int_oe_o && int_do_o == pend));

  assert_soft_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((soft_rst_i || stop_i) && !sw_ctrl && !nv_ctrl) |=> $stable(ctrl_q));
endmodule

bind cfg_gate_ctrl cfg_gate_ctrl_chk #(.ADDR_W(ADDR_W), .PHY_W(PHY_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i), .stop_i(stop_i),
  .sw_we_i(sw_we_i), .sw_addr_i(sw_addr_i), .sw_wdata_i(sw_wdata_i),
  .sw_rdata_o(sw_rdata_o), .nv_we_i(nv_we_i), .nv_addr_i(nv_addr_i),
  .nv_wdata_i(nv_wdata_i), .irq_i(irq_i), .int_do_o(int_do_o),
  .int_oe_o(int_oe_o), .ctrl_q(ctrl_q), .phy_q(phy_q)
);

// File: tb/cfg_gate_ctrl_test.sv
module cfg_gate_ctrl_test;
  logic        clk_i = 0, rst_ni = 1, soft_rst_i = 0, stop_i = 0;
  logic        sw_we_i = 0, nv_we_i = 0, irq_i = 0;
  logic [4:0]  sw_addr_i = 0, nv_addr_i = 0;
  logic [31:0] sw_wdata_i = 0, nv_wdata_i = 0, sw_rdata_o;
  logic        int_do_o, int_oe_o;
  int checks = 0, errors = 0;

  cfg_gate_ctrl uut (.*);

  always #4 clk_i = ~clk_i;

  // bench model: ctrl {phy_en, led_en, sh_en, edge}
  logic [3:0]  m_ctrl;
  logic [1:0]  m_phy;
  logic [15:0] m_led [5];
  logic [31:0] m_sh  [4];

  function automatic logic [31:0] exp_read(int a);
    if (a == 0)            return {18'b0, m_ctrl[3], m_ctrl[2], 3'b0, m_ctrl[1], m_ctrl[0], 7'b0};
    if (a == 1)            return {30'b0, m_phy};
    if (a >= 2 && a <= 6)  return {16'b0, m_led[a-2]};
    if (a >= 8 && a <= 11) return m_sh[a-8];
    return 32'h0;
  endfunction

  task automatic model_wr(bit nv, int a, logic [31:0] d, logic [3:0] c);
    if (a == 0) begin
      logic [31:0] v = nv ? (d & 32'hffff) : d;
      m_ctrl = {v[13], v[12], v[8], v[7]};
    end else if (a == 1 && (nv || c[3])) m_phy = d[1:0];
    else if (a >= 2 && a <= 6 && (nv || c[2])) m_led[a-2] = d[15:0];
    else if (a >= 8 && a <= 11 && (nv || c[1])) m_sh[a-8] = d;
  endtask

  task automatic model_clear();
    m_ctrl = 0; m_phy = 0;
    for (int i = 0; i < 5; i++) m_led[i] = 0;
    for (int i = 0; i < 4; i++) m_sh[i] = 0;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at negedge; commits at posedge, returns at next negedge
  task automatic cycle(bit swe, int sa, logic [31:0] sd, bit nwe, int na, logic [31:0] nd);
    logic [3:0] c = m_ctrl;
    sw_we_i = swe; sw_addr_i = 5'(sa); sw_wdata_i = sd;
    nv_we_i = nwe; nv_addr_i = 5'(na); nv_wdata_i = nd;
    @(posedge clk_i);
    if (swe) model_wr(0, sa, sd, c);
    if (nwe) model_wr(1, na, nd, c);
    @(negedge clk_i);
    sw_we_i = 0; nv_we_i = 0;
  endtask

  task automatic rd(string req, int a);
    sw_addr_i = 5'(a);
    #1;
    check(req, sw_rdata_o, exp_read(a));
  endtask

  task automatic rd_all(string req);
    for (int a = 0; a < 32; a++) rd(req, a);
  endtask

  task automatic pad(string req);
    bit p = irq_i && !soft_rst_i && !stop_i;
    #1;
    if (m_ctrl[0]) check(req, {int_oe_o, int_do_o}, {1'b1, p});
    else           check(req, {int_oe_o, int_do_o}, {p, 1'b0});
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    model_clear();
    #1 rst_ni = 0;
    #20 rst_ni = 1;
    @(negedge clk_i);

    rd_all("R1");
    irq_i = 1; pad("R1_R7");
    irq_i = 0; pad("R7");

    // R2: reserved bits read zero, control writable
    cycle(1, 0, 32'hffff_ffff, 0, 0, 0); rd("R2", 0);
    check("R2", sw_rdata_o, 32'h0000_3180);
    cycle(1, 0, 32'h0, 0, 0, 0); rd("R2", 0);

    // R4: blocked sw write, loader bypass, enabled sw write
    cycle(1, 1, 32'h3, 0, 0, 0); rd("R4", 1);
    cycle(0, 0, 0, 1, 1, 32'h2); rd("R4", 1);
    cycle(1, 0, 32'h2000, 0, 0, 0);
    cycle(1, 1, 32'h1, 0, 0, 0); rd("R4", 1);

    // R5: LED blocked then enabled
    cycle(1, 4, 32'hbeef, 0, 0, 0); rd("R5", 4);
    cycle(0, 0, 0, 1, 5, 32'h1234); rd("R5", 5);
    cycle(1, 5, 32'h9999, 0, 0, 0); rd("R5", 5);
    cycle(1, 0, 32'h1000, 0, 0, 0);
    cycle(1, 6, 32'hcafe_f00d, 0, 0, 0); rd("R5", 6);

    // R6: shadow blocked then enabled
    cycle(1, 9, 32'h1111_2222, 0, 0, 0); rd("R6", 9);
    cycle(0, 0, 0, 1, 10, 32'hdead_beef); rd("R6", 10);
    cycle(1, 0, 32'h0100, 0, 0, 0);
    cycle(1, 11, 32'h5a5a_a5a5, 0, 0, 0); rd("R6", 11);

    // R3: loader masked to 15..0, wins same-address collision
    cycle(0, 0, 0, 1, 0, 32'hffff_ffff); rd("R3", 0);
    cycle(1, 0, 32'h0000_0000, 1, 0, 32'h0000_1080); rd("R3", 0);
    check("R3", sw_rdata_o, 32'h0000_1080);

    // R8 edge mode, R7 level mode
    irq_i = 1; pad("R8"); irq_i = 0; pad("R8");
    cycle(1, 0, 32'h0, 0, 0, 0);
    irq_i = 1; pad("R7"); irq_i = 0; pad("R7");

    // R9: soft reset and stop keep state, mask irq
    cycle(1, 0, 32'h3180, 0, 0, 0);
    soft_rst_i = 1; irq_i = 1;
    cycle(0, 0, 0, 0, 0, 0); pad("R9"); rd_all("R9");
    soft_rst_i = 0; stop_i = 1;
    cycle(0, 0, 0, 0, 0, 0); pad("R9"); rd_all("R9");
    stop_i = 0; pad("R9_R8");

    // R10: unmapped writes change nothing
    cycle(1, 7, 32'hffff_ffff, 0, 0, 0);
    cycle(1, 12, 32'hffff_ffff, 1, 31, 32'hffff_ffff);
    rd_all("R10");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(0, 99);
      bit swe = r < 70;
      int sa = (r < 20) ? 0 : $urandom_range(0, 31);
      bit nwe = $urandom_range(0, 9) == 0;
      int na = $urandom_range(0, 15);
      soft_rst_i = $urandom_range(0, 7) == 0;
      stop_i = $urandom_range(0, 7) == 0;
      irq_i = $urandom_range(0, 1);
      cycle(swe, sa, $urandom(), nwe, na, $urandom());
      rd("R4_R5_R6_R10", $urandom_range(0, 31));
      pad("R7_R8_R9");
    end
    soft_rst_i = 0; stop_i = 0;
    rd_all("R2_R3");

    // hard reset mid-run
    rst_ni = 0; model_clear(); #1;
    rst_ni = 1;
    @(negedge clk_i);
    rd_all("R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule